// File: doc/BRIEF.md
# Direct and Indexed Address Generator

This block does the address arithmetic for direct and indexed memory operands. It holds a 16-bit movable base for direct (zero-page style) operands and two index registers, X and Y. Each cycle it takes an addressing-mode code and an operand, and it produces a 16-bit effective address. It also produces a flag that pins the result to bank zero, a carry flag that tells the caller an indexed sum has crossed into the next bank, and the current index values.

The index registers are 16 bits wide in wide operation. When the index-width bit or the emulation bit is set, they behave as 8-bit registers: writes keep only the low byte, reads and sums see a zero high byte, and the stored high bytes are cleared. Indirect forms are supported only on their arithmetic side. For pre-indexed forms the block forms the pointer location. For post-indexed forms the caller supplies the fetched pointer and the block adds Y to it. The block does not fetch pointers or sequence instructions.

Top module: `dirIdxAgu`

## Requirements
- R1: After reset the direct base, X and Y are all zero, so xVal and yVal read 0 and a direct operand maps to itself.
- R2: Mode code 0 (direct): effAddr = (direct base + operand[7:0]) mod 2^16, bankZero = 1, carryOut = 0.
- R3: Mode codes 1 and 2 (direct indexed by X, by Y): effAddr = (direct base + operand[7:0] + index) mod 2^16, bankZero = 1, carryOut = 0.
- R4: Mode codes 3 and 4 (absolute indexed by X, by Y): effAddr = low 16 bits of operand + index, carryOut = bit 16 of that sum, bankZero = 0.
- R5: Mode code 5 (pre-indexed pointer location): effAddr = (direct base + operand[7:0] + X) mod 2^16, bankZero = 1, carryOut = 0.
- R6: Mode code 6 (post-indexed): operand is the fetched pointer, effAddr = low 16 bits of pointer + Y, carryOut = bit 16, bankZero = 0.
- R7: Mode code 7 (plain): effAddr = operand, bankZero = 0, carryOut = 0.
- R8: With emuMode = 0 and idxNarrow = 0, a write to X or Y stores all 16 bits of wrData, and the new value is visible on xVal or yVal from the next cycle.
- R9: With idxNarrow = 1 or emuMode = 1, the high byte of xVal and yVal reads zero, an index write ignores wrData[15:8], and indexed sums use only the low byte.
- R10: The stored high bytes are cleared while narrow, so after a return to wide operation X and Y keep a zero high byte until they are rewritten.
- R11: A direct-base write always stores all 16 bits of wrData, whatever the index width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| emuMode | input | 1 | Emulation bit; forces narrow index registers |
| idxNarrow | input | 1 | Index-width bit; 1 selects 8-bit index registers |
| modeSel | input | 3 | Addressing-mode code (0 to 7) |
| operand | input | 16 | Operand byte (low 8 bits) or 16-bit base or pointer |
| wrData | input | 16 | Write data for the register write ports |
| wrDirEn | input | 1 | Write strobe for the direct base |
| wrXEn | input | 1 | Write strobe for X |
| wrYEn | input | 1 | Write strobe for Y |
| effAddr | output | 16 | Effective address |
| bankZero | output | 1 | Result is fixed to bank zero |
| carryOut | output | 1 | Indexed sum crossed a 64 KiB boundary |
| xVal | output | 16 | Current X as seen at the current width |
| yVal | output | 16 | Current Y as seen at the current width |

## Verification
Directed patterns come first. A direct base near the top of the space separates a modulo-2^16 wrap from a carry into the bank. Absolute sums with and without a carry out of bit 15 separate the carry flag from the address bits. An index value with a non-zero high byte separates wide operation from narrow operation. The same register is then read in each of the three width states (wide, narrow by the width bit, narrow by emulation), and again after a return to wide, which shows whether the stored high byte was really cleared. A long pseudo-random run then mixes every mode code with writes and width changes, and a behavioural model of the block is compared against the design on every clock.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_DIRECT = 3'd0,
    AM_DIR_X  = 3'd1,
    AM_DIR_Y  = 3'd2,
    AM_ABS_X  = 3'd3,
    AM_ABS_Y  = 3'd4,
    AM_PRE_X  = 3'd5,
    AM_POST_Y = 3'd6,
    AM_PLAIN  = 3'd7
  } addrMode_t;

  typedef struct packed {
    logic wrDir;
    logic wrX;
    logic wrY;
    logic narrow;
    logic useDir;
    logic addIdx;
    logic idxIsY;
    logic zeroBank;
    logic keepCarry;
  } ctrlStrobes_t;
endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic         emuMode,
  input  logic         idxNarrow,
  input  logic [2:0]   modeSel,
  input  logic         wrDirEn,
  input  logic         wrXEn,
  input  logic         wrYEn,
  output ctrlStrobes_t strobes
);
  addrMode_t mode;
  assign mode = addrMode_t'(modeSel);

  always_comb begin
    strobes = '0;
    strobes.wrDir  = wrDirEn;
    strobes.wrX    = wrXEn;
    strobes.wrY    = wrYEn;
    strobes.narrow = idxNarrow | emuMode;
    case (mode)
      AM_DIRECT: begin
        strobes.useDir = 1'b1; strobes.zeroBank = 1'b1;
      end
      AM_DIR_X, AM_PRE_X: begin
        strobes.useDir = 1'b1; strobes.zeroBank = 1'b1; strobes.addIdx = 1'b1;
      end
      AM_DIR_Y: begin
        strobes.useDir = 1'b1; strobes.zeroBank = 1'b1; strobes.addIdx = 1'b1;
        strobes.idxIsY = 1'b1;
      end
      AM_ABS_X: begin
        strobes.addIdx = 1'b1; strobes.keepCarry = 1'b1;
      end
      AM_ABS_Y, AM_POST_Y: begin
        strobes.addIdx = 1'b1; strobes.idxIsY = 1'b1; strobes.keepCarry = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DOFF_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] operand,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] effAddr,
  output logic              bankZero,
  output logic              carryOut,
  output logic [ADDR_W-1:0] xVal,
  output logic [ADDR_W-1:0] yVal
);
  localparam int HALF = ADDR_W / 2;
  localparam int HI_W = ADDR_W - HALF;

  logic [ADDR_W-1:0] dirReg, xReg, yReg;
  logic [ADDR_W-1:0] wrNarrowed, baseAddr, idxTerm;
  logic [ADDR_W:0]   sumWide;

  assign wrNarrowed = strobes.narrow ? {{HI_W{1'b0}}, wrData[HALF-1:0]} : wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0;
      xReg   <= '0;
      yReg   <= '0;
    end else begin
      if (strobes.wrDir) dirReg <= wrData;
      if (strobes.wrX) xReg <= wrNarrowed;
      else if (strobes.narrow) xReg[ADDR_W-1:HALF] <= '0;
      if (strobes.wrY) yReg <= wrNarrowed;
      else if (strobes.narrow) yReg[ADDR_W-1:HALF] <= '0;
    end
  end

  assign xVal = strobes.narrow ? {{HI_W{1'b0}}, xReg[HALF-1:0]} : xReg;
  assign yVal = strobes.narrow ? {{HI_W{1'b0}}, yReg[HALF-1:0]} : yReg;

  assign baseAddr = strobes.useDir
                  ? dirReg + {{(ADDR_W-DOFF_W){1'b0}}, operand[DOFF_W-1:0]}
                  : operand;
  assign idxTerm  = !strobes.addIdx ? '0 : (strobes.idxIsY ? yVal : xVal);
  assign sumWide  = {1'b0, baseAddr} + {1'b0, idxTerm};

  assign effAddr  = sumWide[ADDR_W-1:0];
  assign carryOut = strobes.keepCarry & sumWide[ADDR_W];
  assign bankZero = strobes.zeroBank;
endmodule

// File: rtl/dirIdxAgu.sv
module dirIdxAgu
  import agu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DOFF_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              emuMode,
  input  logic              idxNarrow,
  input  logic [2:0]        modeSel,
  input  logic [ADDR_W-1:0] operand,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              wrDirEn,
  input  logic              wrXEn,
  input  logic              wrYEn,
  output logic [ADDR_W-1:0] effAddr,
  output logic              bankZero,
  output logic              carryOut,
  output logic [ADDR_W-1:0] xVal,
  output logic [ADDR_W-1:0] yVal
);
  ctrlStrobes_t strobes;

  agu_ctrl u_ctrl (
    .emuMode(emuMode), .idxNarrow(idxNarrow), .modeSel(modeSel),
    .wrDirEn(wrDirEn), .wrXEn(wrXEn), .wrYEn(wrYEn), .strobes(strobes)
  );

  agu_datapath #(.ADDR_W(ADDR_W), .DOFF_W(DOFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .operand(operand),
    .wrData(wrData), .effAddr(effAddr), .bankZero(bankZero),
    .carryOut(carryOut), .xVal(xVal), .yVal(yVal)
  );
endmodule

// File: rtl/dirIdxAgu_chk.sv
module dirIdxAgu_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              emuMode,
  input logic              idxNarrow,
  input logic [2:0]        modeSel,
  input logic [ADDR_W-1:0] operand,
  input logic [ADDR_W-1:0] wrData,
  input logic              wrXEn,
  input logic [ADDR_W-1:0] effAddr,
  input logic              bankZero,
  input logic              carryOut,
  input logic [ADDR_W-1:0] xVal,
  input logic [ADDR_W-1:0] yVal
);
  localparam int HALF = ADDR_W / 2;
  logic narrowNow;
  assign narrowNow = idxNarrow | emuMode;

  a_r2_direct_in_bank0: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd0) |-> (bankZero && !carryOut));

  a_r3_dir_idx_no_carry: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd1 || modeSel == 3'd2 || modeSel == 3'd5) |-> (bankZero && !carryOut));

  a_r4_abs_x_sum: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd3) |->
      ({carryOut, effAddr} == ({1'b0, operand} + {1'b0, xVal})) && !bankZero);

  a_r6_post_y_sum: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd6) |->
      ({carryOut, effAddr} == ({1'b0, operand} + {1'b0, yVal})) && !bankZero);

  a_r7_plain_pass: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd7) |-> (effAddr == operand && !bankZero && !carryOut));

  a_r9_narrow_hi_zero: assert property (@(posedge clk) disable iff (!rstN)
    narrowNow |-> (xVal[ADDR_W-1:HALF] == '0 && yVal[ADDR_W-1:HALF] == '0));

  a_r8_wide_x_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrXEn && !narrowNow) |=> (narrowNow || xVal == $past(wrData)));
endmodule

bind dirIdxAgu dirIdxAgu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .emuMode(emuMode), .idxNarrow(idxNarrow),
  .modeSel(modeSel), .operand(operand), .wrData(wrData), .wrXEn(wrXEn),
  .effAddr(effAddr), .bankZero(bankZero), .carryOut(carryOut),
  .xVal(xVal), .yVal(yVal)
);

// File: tb/dirIdxAgu_tb.sv
module dirIdxAgu_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        emuMode = 1'b0, idxNarrow = 1'b0;
  logic [2:0]  modeSel = 3'd0;
  logic [15:0] operand = '0, wrData = '0;
  logic        wrDirEn = 1'b0, wrXEn = 1'b0, wrYEn = 1'b0;
  logic [15:0] effAddr, xVal, yVal;
  logic        bankZero, carryOut;

  int checks = 0, failures = 0;
  int dirM = 0, xM = 0, yM = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dirIdxAgu u_dut (
    .clk(clk), .rstN(rstN), .emuMode(emuMode), .idxNarrow(idxNarrow),
    .modeSel(modeSel), .operand(operand), .wrData(wrData),
    .wrDirEn(wrDirEn), .wrXEn(wrXEn), .wrYEn(wrYEn),
    .effAddr(effAddr), .bankZero(bankZero), .carryOut(carryOut),
    .xVal(xVal), .yVal(yVal)
  );

  function automatic string tagOf(int m);
    case (m)
      0: return "R2";
      1, 2: return "R3";
      3, 4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Compare outputs against the model, then advance one clock and update the model.
  task automatic step(input int m, input int op, input bit nar, input bit emu,
                      input bit wd, input bit wx, input bit wy, input int wv,
                      input string tag);
    int xr, yr, s, eaE, bzE, cE;
    bit narE;
    @(negedge clk);
    modeSel = 3'(m); operand = 16'(op); idxNarrow = nar; emuMode = emu;
    wrDirEn = wd; wrXEn = wx; wrYEn = wy; wrData = 16'(wv);
    #2;
    narE = nar | emu;
    xr = narE ? (xM & 255) : xM;
    yr = narE ? (yM & 255) : yM;
    bzE = 0; cE = 0;
    case (m)
      0: begin eaE = (dirM + (op & 255)) & 16'hFFFF; bzE = 1; end
      1, 5: begin eaE = (dirM + (op & 255) + xr) & 16'hFFFF; bzE = 1; end
      2: begin eaE = (dirM + (op & 255) + yr) & 16'hFFFF; bzE = 1; end
      3: begin s = op + xr; eaE = s & 16'hFFFF; cE = s >> 16; end
      4, 6: begin s = op + yr; eaE = s & 16'hFFFF; cE = s >> 16; end
      default: eaE = op;
    endcase
    checks++;
    if (int'(effAddr) != eaE || int'(bankZero) != bzE || int'(carryOut) != cE ||
        int'(xVal) != xr || int'(yVal) != yr) begin
      failures++;
      $display("FAIL %s mode=%0d: ea=%h bz=%0d c=%0d x=%h y=%h expected ea=%h bz=%0d c=%0d x=%h y=%h",
               tag, m, effAddr, bankZero, carryOut, xVal, yVal, eaE, bzE, cE, xr, yr);
    end
    @(posedge clk);
    if (wd) dirM = wv & 16'hFFFF;
    if (wx) xM = narE ? (wv & 255) : (wv & 16'hFFFF);
    else if (narE) xM = xM & 255;
    if (wy) yM = narE ? (wv & 255) : (wv & 16'hFFFF);
    else if (narE) yM = yM & 255;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lfsr;
    repeat (2) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1: reset state
    step(0, 16'h0034, 0, 0, 0, 0, 0, 0, "R1");
    // R11 direct write while narrow keeps 16 bits; R8 wide writes
    step(7, 16'h5555, 1, 0, 1, 0, 0, 16'hFFF0, "R11");
    step(0, 16'h0020, 0, 0, 0, 1, 0, 16'hABCD, "R2");   // direct wraps to 0x0010
    step(1, 16'h0020, 0, 0, 0, 0, 1, 16'h8001, "R8");
    step(2, 16'h0010, 0, 0, 1, 0, 0, 16'h1200, "R3");
    step(3, 16'h0100, 0, 0, 0, 0, 0, 0, "R4");          // no carry
    step(3, 16'hFFF0, 0, 0, 0, 0, 0, 0, "R4");          // carry out
    step(4, 16'h9000, 0, 0, 0, 0, 0, 0, "R4");
    step(5, 16'h00FE, 0, 0, 0, 0, 0, 0, "R5");
    step(6, 16'h7FFF, 0, 0, 0, 0, 0, 0, "R6");
    step(6, 16'h0001, 0, 0, 0, 0, 0, 0, "R6");
    step(7, 16'hBEEF, 0, 0, 0, 0, 0, 0, "R7");
    // R9 narrow via width bit: write ignores high byte
    step(3, 16'hFFFF, 1, 0, 0, 1, 0, 16'h12F4, "R9");
    step(3, 16'hFFFF, 1, 0, 0, 0, 0, 0, "R9");
    // R10 back to wide: high bytes stay zero
    step(4, 16'h0000, 0, 0, 0, 0, 0, 0, "R10");
    step(3, 16'h0000, 0, 0, 0, 1, 1, 16'hC3A5, "R8");
    // R9 narrow via emulation bit
    step(1, 16'h00FF, 0, 1, 0, 0, 0, 0, "R9");
    step(4, 16'hFF80, 0, 0, 0, 0, 0, 0, "R10");
    // pseudo-random mix of every mode, writes and width changes
    lfsr = 32'h1ACE5;
    for (int i = 0; i < 3000; i++) begin
      int m;
      lfsr = (lfsr << 1) ^ (((lfsr >> 31) ^ (lfsr >> 21) ^ (lfsr >> 1) ^ lfsr) & 1);
      m = lfsr & 7;
      step(m, (lfsr >> 3) & 16'hFFFF, ((lfsr >> 19) & 7) == 0, ((lfsr >> 22) & 15) == 0,
           ((lfsr >> 26) & 7) == 0, ((lfsr >> 29) & 3) == 0, ((lfsr >> 9) & 3) == 0,
           (lfsr >> 11) & 16'hFFFF, tagOf(m));
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule